// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Write Buffer

This block sits between a CPU load/store port and a slower word-wide external memory port. Loads whose address falls in the selected cacheable area are served from a 1 KB direct-mapped store of 64 lines, each 16 bytes. A miss fetches the whole line from memory before the load completes. Loads outside the area, and all loads while the cache is off or being flushed, go to memory as single-word reads and are not kept.

Every store goes to memory. A store that hits also updates the cached word, and a store that misses allocates nothing. When the buffer enable is set, a store is captured in a one-entry buffer and accepted at once; the buffer drains to memory on the following cycles. When the buffer enable is clear, the store is held until memory acknowledges it.

Clearing the cache enable starts a walk that invalidates one line per cycle. A busy status output stays high for the whole walk, and the cache is bypassed while it runs. The CPU keeps its request, address and write data stable until it sees ready. Memory acknowledges with a one-cycle pulse, and read data is valid in that cycle.

Top module: `wt_dcache`

## Requirements
- R1: Out of reset, mem_req, cpu_ready (with no request) and stat_flush_busy are all low.
- R2: The area number is cpu_addr[23:19]. Area code 0 selects area 14, code 1 selects areas 15 and 16, and code k from 2 to 7 selects area 15+k. An address outside the selected area is never cached.
- R3: A cacheable load that misses performs exactly four memory word reads, at the line base plus 0, 4, 8 and 12 in that order. It then returns the word. A load that hits is ready in the cycle it is presented, with no memory request.
- R4: A load that is not cacheable performs one memory word read. It is ready in the acknowledge cycle with the memory data and allocates nothing, so a repeat load reads memory again.
- R5: Every store produces exactly one memory write, carrying the word-aligned address and the store data.
- R6: With cfg_wbuf_en=1 and the buffer empty, a store is ready in the cycle it is presented, and its memory write follows later.
- R7: While the buffer holds a store, every request stalls until memory acknowledges that store. A load issued right after a buffered store to the same address returns the stored data.
- R8: With cfg_wbuf_en=0, a store is ready exactly in the cycle mem_ack is high.
- R9: A store that hits updates the cached word. A store that misses allocates no line, so a following load to that line performs a full line fill.
- R10: When cfg_en falls, stat_flush_busy rises in the same cycle and stays high for exactly 64 cycles, after which every line is invalid. Loads issued while busy is high are single-word memory reads.
- R11: cpu_addr[1:0] are ignored; all accesses are whole words.
- R12: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Cache enable; a falling edge starts the flush |
| cfg_wbuf_en | input | 1 | Posted write buffer enable |
| cfg_area | input | 3 | Cacheable area code |
| stat_flush_busy | output | 1 | High while the invalidation walk runs |
| cpu_req | input | 1 | CPU access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 24 | CPU byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | External memory write |
| mem_addr | output | 24 | External word-aligned address |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are those where two timelines overlap. One is a load queued behind a posted store that has not yet drained. The other is a load presented during the 64-cycle invalidation window, and a fill racing that window. The bench reaches the first by issuing a store and then, on the very next cycle, a second access to the same word. It reaches the second by toggling the enable off and back on within a cycle and loading a line that was resident just before. Area decoding is swept across all eight codes against twelve neighbouring areas, and the number of memory reads each load causes is counted.

// File: rtl/wtdc_pkg.sv
package wtdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_FILL
    } ctl_st_e;

    // Map a 3-bit area code onto the address-space area number it enables.
    function automatic logic area_hit(input logic [4:0] area, input logic [2:0] code);
        logic m;
        if (code == 3'd0)      m = (area == 5'd14);
        else if (code == 3'd1) m = (area == 5'd15) || (area == 5'd16);
        else                   m = (area == (5'(code) + 5'd15));
        return m;
    endfunction

endpackage

// File: rtl/wtdc_tags.sv
module wtdc_tags #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [IDX_W-1:0] lk_idx_i,
    input  logic [TAG_W-1:0] lk_tag_i,
    input  logic             fill_we_i,
    output logic             hit_o,
    output logic             busy_o
);

    typedef struct packed {
        logic [LINES-1:0] valid;
        logic             flushing;
        logic [IDX_W-1:0] ptr;
        logic             en_q;
    } tag_st_t;

    tag_st_t          st_d, st_q;
    logic [TAG_W-1:0] tag_mem [LINES];
    logic             start;

    always_comb begin
        st_d      = st_q;
        st_d.en_q = en_i;
        start     = st_q.en_q & ~en_i;
        if (st_q.flushing) begin
            st_d.valid[st_q.ptr] = 1'b0;
            st_d.ptr             = st_q.ptr + 1'b1;
            if (st_q.ptr == IDX_W'(LINES - 1)) begin
                st_d.flushing = 1'b0;
            end
        end else if (start) begin
            st_d.valid[0] = 1'b0;
            st_d.ptr      = IDX_W'(1);
            st_d.flushing = 1'b1;
        end else if (fill_we_i) begin
            st_d.valid[lk_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we_i) begin
            tag_mem[lk_idx_i] <= lk_tag_i;
        end
    end

    assign hit_o  = st_q.valid[lk_idx_i] && (tag_mem[lk_idx_i] == lk_tag_i);
    assign busy_o = st_q.flushing | start;

    // R10: the walk leaves no line valid behind it
    a_r10_flush_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flushing) |-> (st_q.valid == '0));

    // R10: a line is never validated while the walk is running
    a_r10_no_fill_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fill_we_i);

endmodule

// File: rtl/wtdc_data.sv
module wtdc_data #(
    parameter int DEPTH  = 256,
    parameter int AW     = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/wtdc_ctrl.sv
module wtdc_ctrl
    import wtdc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int WSEL_W = 2,
    parameter int TAG_W  = 14,
    parameter int AREA_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic                    wbuf_en_i,
    input  logic [2:0]              area_sel_i,
    input  logic                    busy_i,
    input  logic                    hit_i,
    input  logic                    cpu_req_i,
    input  logic                    cpu_we_i,
    input  logic [ADDR_W-1:0]       cpu_addr_i,
    input  logic [DATA_W-1:0]       cpu_wdata_i,
    output logic [DATA_W-1:0]       cpu_rdata_o,
    output logic                    cpu_ready_o,
    output logic                    mem_req_o,
    output logic                    mem_we_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [DATA_W-1:0]       mem_wdata_o,
    input  logic [DATA_W-1:0]       mem_rdata_i,
    input  logic                    mem_ack_i,
    output logic [IDX_W-1:0]        lk_idx_o,
    output logic [TAG_W-1:0]        lk_tag_o,
    output logic                    fill_we_o,
    output logic                    dat_we_o,
    output logic [IDX_W+WSEL_W-1:0] dat_waddr_o,
    output logic [DATA_W-1:0]       dat_wdata_o,
    output logic [IDX_W+WSEL_W-1:0] dat_raddr_o,
    input  logic [DATA_W-1:0]       dat_rdata_i
);

    localparam int OFF_W = WSEL_W + 2;

    typedef struct packed {
        ctl_st_e           st;
        logic              wb_valid;
        logic [ADDR_W-3:0] wb_waddr;
        logic [DATA_W-1:0] wb_data;
        logic [WSEL_W-1:0] beat;
    } ctl_st_t;

    ctl_st_t           cs_d, cs_q;
    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] wsel;
    logic [ADDR_W-3:0] waddr;
    logic              cacheable;
    logic              unused_lo;

    assign unused_lo = ^cpu_addr_i[1:0];
    assign idx       = cpu_addr_i[OFF_W +: IDX_W];
    assign wsel      = cpu_addr_i[2 +: WSEL_W];
    assign waddr     = cpu_addr_i[ADDR_W-1:2];
    assign cacheable = en_i & ~busy_i & area_hit(cpu_addr_i[ADDR_W-1 -: AREA_W], area_sel_i);

    assign lk_idx_o    = idx;
    assign lk_tag_o    = cpu_addr_i[ADDR_W-1 -: TAG_W];
    assign dat_raddr_o = {idx, wsel};

    always_comb begin
        cs_d        = cs_q;
        cpu_ready_o = 1'b0;
        cpu_rdata_o = dat_rdata_i;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = {waddr, 2'b00};
        mem_wdata_o = cpu_wdata_i;
        fill_we_o   = 1'b0;
        dat_we_o    = 1'b0;
        dat_waddr_o = {idx, wsel};
        dat_wdata_o = cpu_wdata_i;
        unique case (cs_q.st)
            ST_IDLE: begin
                if (cs_q.wb_valid) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = {cs_q.wb_waddr, 2'b00};
                    mem_wdata_o = cs_q.wb_data;
                    if (mem_ack_i) begin
                        cs_d.wb_valid = 1'b0;
                    end
                end else if (cpu_req_i) begin
                    if (cpu_we_i) begin
                        if (wbuf_en_i) begin
                            cpu_ready_o   = 1'b1;
                            cs_d.wb_valid = 1'b1;
                            cs_d.wb_waddr = waddr;
                            cs_d.wb_data  = cpu_wdata_i;
                            dat_we_o      = cacheable & hit_i;
                        end else begin
                            cs_d.st = ST_WRITE;
                        end
                    end else if (cacheable && hit_i) begin
                        cpu_ready_o = 1'b1;
                    end else if (cacheable) begin
                        cs_d.st   = ST_FILL;
                        cs_d.beat = '0;
                    end else begin
                        cs_d.st = ST_READ;
                    end
                end
            end
            ST_WRITE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ack_i) begin
                    cpu_ready_o = 1'b1;
                    dat_we_o    = cacheable & hit_i;
                    cs_d.st     = ST_IDLE;
                end
            end
            ST_READ: begin
                mem_req_o   = 1'b1;
                cpu_rdata_o = mem_rdata_i;
                if (mem_ack_i) begin
                    cpu_ready_o = 1'b1;
                    cs_d.st     = ST_IDLE;
                end
            end
            ST_FILL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {cpu_addr_i[ADDR_W-1:OFF_W], cs_q.beat, 2'b00};
                if (mem_ack_i) begin
                    dat_we_o    = 1'b1;
                    dat_waddr_o = {idx, cs_q.beat};
                    dat_wdata_o = mem_rdata_i;
                    cs_d.beat   = cs_q.beat + 1'b1;
                    if (cs_q.beat == '1) begin
                        fill_we_o = en_i & ~busy_i;
                        cs_d.st   = ST_IDLE;
                    end
                end
            end
            default: cs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{st: ST_IDLE, default: '0};
        end else begin
            cs_q <= cs_d;
        end
    end

    // R12: a memory request holds its command until acknowledged
    a_r12_mem_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R7: a pending buffered store blocks every new access
    a_r7_buffer_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.wb_valid && cpu_req_i) |-> !cpu_ready_o);

    // R8: an unbuffered store completes only with the memory acknowledge
    a_r8_sync_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_we_i && !wbuf_en_i && cpu_ready_o) |-> mem_ack_i);

    // R3: completions without an acknowledge are hits or posted stores, with no bus traffic
    a_r3_quiet_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready_o && !mem_ack_i) |-> !mem_req_o);

    // R1: ready is only ever given to a live request
    a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> cpu_req_i);

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 32,
    parameter int LINES      = 64,
    parameter int LINE_WORDS = 4,
    parameter int AREA_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wbuf_en,
    input  logic [2:0]        cfg_area,
    output logic              stat_flush_busy,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int DAT_AW = IDX_W + WSEL_W;
    localparam int DEPTH  = LINES * LINE_WORDS;

    logic              hit, busy, fill_we, dat_we;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [DAT_AW-1:0] dat_waddr, dat_raddr;
    logic [DATA_W-1:0] dat_wdata, dat_rdata;

    assign stat_flush_busy = busy;

    wtdc_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (cfg_en),
        .lk_idx_i  (lk_idx),
        .lk_tag_i  (lk_tag),
        .fill_we_i (fill_we),
        .hit_o     (hit),
        .busy_o    (busy)
    );

    wtdc_data #(.DEPTH(DEPTH), .AW(DAT_AW), .DATA_W(DATA_W)) data_i (
        .clk     (clk),
        .we_i    (dat_we),
        .waddr_i (dat_waddr),
        .wdata_i (dat_wdata),
        .raddr_i (dat_raddr),
        .rdata_o (dat_rdata)
    );

    wtdc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .WSEL_W(WSEL_W), .TAG_W(TAG_W), .AREA_W(AREA_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cfg_en),
        .wbuf_en_i   (cfg_wbuf_en),
        .area_sel_i  (cfg_area),
        .busy_i      (busy),
        .hit_i       (hit),
        .cpu_req_i   (cpu_req),
        .cpu_we_i    (cpu_we),
        .cpu_addr_i  (cpu_addr),
        .cpu_wdata_i (cpu_wdata),
        .cpu_rdata_o (cpu_rdata),
        .cpu_ready_o (cpu_ready),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_ack_i   (mem_ack),
        .lk_idx_o    (lk_idx),
        .lk_tag_o    (lk_tag),
        .fill_we_o   (fill_we),
        .dat_we_o    (dat_we),
        .dat_waddr_o (dat_waddr),
        .dat_wdata_o (dat_wdata),
        .dat_raddr_o (dat_raddr),
        .dat_rdata_i (dat_rdata)
    );

endmodule

// File: tb/wt_dcache_tb_top.sv
module wt_dcache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en, cfg_wbuf_en;
    logic [2:0]  cfg_area;
    logic        stat_flush_busy;
    logic        cpu_req, cpu_we;
    logic [23:0] cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;

    int ntests = 0;
    int nfail  = 0;
    int nrd    = 0;
    int nwr    = 0;
    int stab_err = 0;
    logic [23:0] last_waddr;
    logic [31:0] last_wdata;
    logic [23:0] rlog[$];
    logic [31:0] wmem[int];

    always #5 clk = ~clk;

    wt_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wbuf_en(cfg_wbuf_en),
        .cfg_area(cfg_area), .stat_flush_busy(stat_flush_busy),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] memval(input logic [23:0] a);
        logic [23:0] w;
        w = {a[23:2], 2'b00};
        if (wmem.exists(int'(w))) return wmem[int'(w)];
        return {8'hC3, w} ^ 32'h0000_5A5A;
    endfunction

    function automatic bit exp_cacheable(input int code, input int area);
        if (code == 0) return area == 14;
        if (code == 1) return (area == 15) || (area == 16);
        return area == code + 15;
    endfunction

    // external memory model: acknowledge two cycles after a request
    int wcnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt == 1) begin
                wcnt = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    wmem[int'({mem_addr[23:2], 2'b00})] = mem_wdata;
                    nwr = nwr + 1;
                    last_waddr = mem_addr;
                    last_wdata = mem_wdata;
                end else begin
                    mem_rdata <= memval(mem_addr);
                    nrd = nrd + 1;
                    rlog.push_back(mem_addr);
                end
            end else begin
                wcnt = wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // request stability monitor
    logic        pend = 1'b0;
    logic [23:0] p_addr;
    logic [31:0] p_wdata;
    logic        p_we;
    always @(posedge clk) begin
        if (rst_n) begin
            if (pend && (!mem_req || mem_addr !== p_addr || mem_we !== p_we ||
                         (mem_we && mem_wdata !== p_wdata)))
                stab_err = stab_err + 1;
            pend    = mem_req && !mem_ack;
            p_addr  = mem_addr;
            p_we    = mem_we;
            p_wdata = mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int          cyc;
    logic [31:0] rd;
    logic        ack_at_rdy;
    int          wr_at_rdy;

    task automatic acc(input logic we, input logic [23:0] a, input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        ack_at_rdy = mem_ack;
        wr_at_rdy = nwr;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", ntests + 1, nfail);
        $finish;
    end

    initial begin
        int n0, nbusy;
        logic [23:0] a;
        rst_n = 1'b0; cfg_en = 1'b0; cfg_wbuf_en = 1'b1; cfg_area = 3'd0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 busy", 32'(stat_flush_busy), 0);
        chk("R1 ready", 32'(cpu_ready), 0);

        // R2 sweep: every code against areas 12..23
        cfg_en = 1'b1;
        for (int code = 0; code < 8; code++) begin
            cfg_area = 3'(code);
            for (int ar = 12; ar < 24; ar++) begin
                bit c;
                c = exp_cacheable(code, ar);
                a = {5'(ar), 19'h00140};
                n0 = nrd; acc(1'b0, a, '0);
                chk("R2 first load reads", 32'(nrd - n0), c ? 4 : 1);
                chk("R3 R4 first load data", rd, memval(a));
                n0 = nrd; acc(1'b0, a, '0);
                chk("R2 repeat load reads", 32'(nrd - n0), c ? 0 : 1);
                chk("R3 R4 repeat load data", rd, memval(a));
                if (c) chk("R3 hit same cycle", 32'(cyc), 0);
            end
        end

        // R3 fill order, critical word in the middle of a line
        cfg_area = 3'd2;
        rlog.delete();
        acc(1'b0, 24'h880128, '0);
        chk("R3 fill beats", 32'(rlog.size()), 4);
        for (int k = 0; k < 4; k++) chk("R3 fill order", 32'(rlog[k]), 32'(24'h880120 + 4 * k));
        for (int k = 0; k < 4; k++) begin
            n0 = nrd;
            acc(1'b0, 24'h880120 + 24'(4 * k), '0);
            chk("R3 line word hit", rd, memval(24'h880120 + 24'(4 * k)));
            chk("R3 line word no read", 32'(nrd - n0), 0);
        end
        // R11 low address bits ignored
        n0 = nrd; acc(1'b0, 24'h88012B, '0);
        chk("R11 unaligned hit data", rd, memval(24'h880128));
        chk("R11 unaligned no read", 32'(nrd - n0), 0);

        // R6 / R5 buffered store to a resident word
        cfg_wbuf_en = 1'b1;
        n0 = nwr; acc(1'b1, 24'h880125, 32'h1111_2222);
        chk("R6 posted accept cycle", 32'(cyc), 0);
        idle(6);
        chk("R5 one write", 32'(nwr - n0), 1);
        chk("R5 write addr", 32'(last_waddr), 32'h880124);
        chk("R5 write data", last_wdata, 32'h1111_2222);
        n0 = nrd; acc(1'b0, 24'h880124, '0);
        chk("R9 hit updated", rd, 32'h1111_2222);
        chk("R9 hit no read", 32'(nrd - n0), 0);

        // R7 back-to-back: second store waits for the first to drain
        n0 = nwr;
        acc(1'b1, 24'h680010, 32'hAAAA_0001);
        acc(1'b1, 24'h680014, 32'hBBBB_0002);
        chk("R7 second store waited", 32'(cyc > 0), 1);
        chk("R7 first drained before accept", 32'(wr_at_rdy - n0), 1);
        acc(1'b0, 24'h680014, '0);
        chk("R7 load after posted store", rd, 32'hBBBB_0002);
        chk("R7 load stalled", 32'(cyc > 0), 1);

        // R8 unbuffered store
        cfg_wbuf_en = 1'b0;
        n0 = nwr; acc(1'b1, 24'h680020, 32'hCAFE_0003);
        chk("R8 ready with ack", 32'(ack_at_rdy), 1);
        chk("R8 write done at ready", 32'(wr_at_rdy - n0), 1);

        // R9 store miss allocates nothing
        n0 = nwr; acc(1'b1, 24'h8804A0, 32'h5555_6666);
        chk("R5 miss store writes", 32'(nwr - n0), 1);
        n0 = nrd; acc(1'b0, 24'h8804A0, '0);
        chk("R9 miss no allocate", 32'(nrd - n0), 4);
        chk("R9 miss then load data", rd, 32'h5555_6666);
        cfg_wbuf_en = 1'b1;

        // R10 flush length and invalidation
        n0 = nrd; acc(1'b0, 24'h880120, '0);
        chk("R10 line resident", 32'(nrd - n0), 0);
        @(negedge clk); cfg_en = 1'b0; #1;
        chk("R10 busy immediate", 32'(stat_flush_busy), 1);
        nbusy = 0;
        while (stat_flush_busy) begin @(negedge clk); #1; nbusy++; end
        chk("R10 busy length", 32'(nbusy), 64);
        cfg_en = 1'b1;
        n0 = nrd; acc(1'b0, 24'h880120, '0);
        chk("R10 refill after flush", 32'(nrd - n0), 4);
        n0 = nrd; acc(1'b0, 24'h8804A0, '0);
        chk("R10 second line invalid", 32'(nrd - n0), 4);

        // R10 load during the walk bypasses the cache
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk); cfg_en = 1'b1;
        n0 = nrd; acc(1'b0, 24'h880120, '0);
        chk("R10 bypass while busy", 32'(nrd - n0), 1);
        chk("R10 bypass data", rd, memval(24'h880120));
        while (stat_flush_busy) @(negedge clk);
        n0 = nrd; acc(1'b0, 24'h880120, '0);
        chk("R10 refill after second walk", 32'(nrd - n0), 4);

        idle(4);
        chk("R12 request stability", 32'(stab_err), 0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule